// File: doc/BRIEF.md
# Regulator Start-Up and Fault Sequencer

This block is the digital supervisor of a synchronous step-down converter. It takes one-bit flags from the analog comparators around the power stage (enable, input undervoltage, overtemperature, feedback above the high threshold, feedback below the low threshold, feedback inside the regulation window, negative current limit reached, peak current limit hit, soft-start level above feedback) together with a strobe that marks each switching period. From these flags it decides whether the power stage may switch, what soft-start ramp code to hand the reference generator, when the low-side switch must be forced on, whether reverse inductor current must be blocked, and whether power-good is reported.

All time windows are counted in switching periods, so every timer advances only on cycles where the strobe is high. Shutdown requests are the exception: they act on the next clock edge, whatever the strobe is doing. The block moves between six states: off, soft start, running, hiccup, overvoltage sink and overvoltage hold. All outputs are registered and change on the same edge as the state.

Top module: `buck_supervisor`

## Requirements
- R1: After reset, with enable low, run_o, force_ls_o, block_rev_o and pgood_o are 0 and ramp_o is 0, and they stay so while enable is low.
- R2: On the first strobe with enable high and no fault, run_o goes to 1 and ramp_o starts at 0. ramp_o then rises by one scaled step per strobe for SS_CYCLES strobes. The next strobe enters running, where ramp_o is all ones.
- R3: No timer, filter or state transition advances on a clock where tick is 0, except a shutdown.
- R4: During soft start block_rev_o is 1 until ss_above_fb_i has been seen high. It then stays 0 for the rest of that soft start, and it is 0 in every other state.
- R5: Enable low, uv_i high or ot_i high forces the off state on the next edge: run_o, force_ls_o and pgood_o go to 0 and ramp_o to 0. This takes priority over every other transition on that edge. Once the condition clears, the next strobe starts a fresh soft start at ramp code 0.
- R6: Each strobe with ilim_i high, in soft start or running, counts one limit hit. The hit that takes the count above OC_LIMIT enters hiccup, where run_o and force_ls_o are both 0.
- R7: Hiccup lasts HICCUP_CYCLES strobes. The strobe after them starts a new soft start.
- R8: The hit count is cleared on entry to hiccup, on shutdown, and when a soft start completes with no hit during it.
- R9: OV_FILTER consecutive strobes with fb_hi_i high, in soft start or running, enter the overvoltage sink state: force_ls_o goes to 1 and run_o to 0. A strobe with fb_hi_i low restarts that count.
- R10: The sink state holds force_ls_o at 1 until a strobe with neg_lim_i high. The block then holds both switches off until a strobe with fb_lo_i high, and then starts a soft start.
- R11: In running, pgood_o goes to 1 on a strobe with fb_ok_i high. It falls only on the PG_FILTER-th consecutive strobe with fb_ok_i low. A shorter excursion leaves it at 1.
- R12: pgood_o is 0 in every state except running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe per switching period |
| en_i | input | 1 | Enable comparator output |
| uv_i | input | 1 | Input undervoltage flag |
| ot_i | input | 1 | Overtemperature flag |
| fb_hi_i | input | 1 | Feedback above overvoltage threshold |
| fb_lo_i | input | 1 | Feedback below restart threshold |
| fb_ok_i | input | 1 | Feedback inside the regulation window |
| neg_lim_i | input | 1 | Low-side current reached the negative limit |
| ilim_i | input | 1 | Peak current limit hit this period |
| ss_above_fb_i | input | 1 | Soft-start level exceeds feedback |
| run_o | output | 1 | Power stage may switch |
| ramp_o | output | RAMP_W | Soft-start ramp code |
| force_ls_o | output | 1 | Force the low-side switch on |
| block_rev_o | output | 1 | Block reverse inductor current |
| pgood_o | output | 1 | Power-good |

## Verification
The bench builds the block with SS_CYCLES=16, HICCUP_CYCLES=32, OC_LIMIT=3, OV_FILTER=4, PG_FILTER=4 and RAMP_W=4. With these values the ramp code equals the soft-start count, so every step can be compared exactly. A complete hiccup retry fits in a few dozen clocks. The limit count, overvoltage filter and power-good filter can each be driven one strobe short of their thresholds and then exactly onto them.

// File: rtl/bsup_pkg.sv
package bsup_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_SOFT    = 3'd1,
    ST_RUN     = 3'd2,
    ST_HICCUP  = 3'd3,
    ST_OV_SINK = 3'd4,
    ST_OV_HOLD = 3'd5
  } bsup_state_e;
endpackage

// File: rtl/bsup_ramp.sv
// Maps the soft-start timer onto the ramp code width.
module bsup_ramp #(
  parameter int SS_W   = 11,
  parameter int TMR_W  = 13,
  parameter int RAMP_W = 8
) (
  input  logic              in_soft,
  input  logic              in_run,
  input  logic [TMR_W-1:0]  count,
  output logic [RAMP_W-1:0] code
);
  logic [RAMP_W-1:0] scaled;

  generate
    if (SS_W >= RAMP_W) begin : g_shift_down
      assign scaled = count[SS_W-1:SS_W-RAMP_W];
    end else begin : g_shift_up
      assign scaled = {count[SS_W-1:0], {(RAMP_W-SS_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    if (in_run)       code = '1;
    else if (in_soft) code = scaled;
    else              code = '0;
  end
endmodule

// File: rtl/bsup_pgood.sv
// Power-good with a strobe-counted drop-out filter; active only in running.
module bsup_pgood #(
  parameter int FILTER = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic in_run,
  input  logic fb_ok,
  output logic pgood
);
  localparam int CW = $clog2(FILTER) + 1;
  logic [CW-1:0] bad_q;

  always_ff @(posedge clk) begin
    if (rst || !in_run) begin
      bad_q <= '0;
      pgood <= 1'b0;
    end else if (tick) begin
      if (fb_ok) begin
        bad_q <= '0;
        pgood <= 1'b1;
      end else if (bad_q == CW'(FILTER - 1)) begin
        pgood <= 1'b0;
      end else begin
        bad_q <= bad_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
  import bsup_pkg::*;
#(
  parameter int SS_CYCLES     = 2048,
  parameter int HICCUP_CYCLES = 4096,
  parameter int OC_LIMIT      = 10,
  parameter int OV_FILTER     = 16,
  parameter int PG_FILTER     = 16,
  parameter int RAMP_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en_i,
  input  logic              uv_i,
  input  logic              ot_i,
  input  logic              fb_hi_i,
  input  logic              fb_lo_i,
  input  logic              fb_ok_i,
  input  logic              neg_lim_i,
  input  logic              ilim_i,
  input  logic              ss_above_fb_i,
  output logic              run_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              force_ls_o,
  output logic              block_rev_o,
  output logic              pgood_o
);
  localparam int SS_W  = $clog2(SS_CYCLES);
  localparam int TMAX  = (HICCUP_CYCLES > SS_CYCLES) ? HICCUP_CYCLES : SS_CYCLES;
  localparam int TMR_W = $clog2(TMAX) + 1;
  localparam int OC_W  = $clog2(OC_LIMIT + 1) + 1;
  localparam int OV_W  = $clog2(OV_FILTER) + 1;

  bsup_state_e      st_q, st_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic [OC_W-1:0]  oc_q, oc_n;
  logic [OV_W-1:0]  ov_q, ov_n;
  logic             hit_q, hit_n;
  logic             rev_ok_q, rev_ok_n;
  logic             shut, oc_trip, ov_trip;
  logic [RAMP_W-1:0] ramp_n;

  assign shut    = !en_i || uv_i || ot_i;
  assign oc_trip = tick && ilim_i && (oc_q == OC_W'(OC_LIMIT));
  assign ov_trip = tick && fb_hi_i && (ov_q == OV_W'(OV_FILTER - 1));

  always_comb begin
    st_n     = st_q;
    tmr_n    = tmr_q;
    oc_n     = oc_q;
    ov_n     = ov_q;
    hit_n    = hit_q;
    rev_ok_n = rev_ok_q;
    unique case (st_q)
      ST_OFF: if (tick) st_n = ST_SOFT;
      ST_SOFT, ST_RUN: begin
        if (st_q == ST_SOFT && ss_above_fb_i) rev_ok_n = 1'b1;
        if (tick) begin
          if (ilim_i) begin
            oc_n = oc_q + 1'b1;
            if (st_q == ST_SOFT) hit_n = 1'b1;
          end
          ov_n = fb_hi_i ? ov_q + 1'b1 : '0;
          if (oc_trip) begin
            st_n = ST_HICCUP;
            oc_n = '0;
          end else if (ov_trip) begin
            st_n = ST_OV_SINK;
          end else if (st_q == ST_SOFT) begin
            if (tmr_q == TMR_W'(SS_CYCLES - 1)) begin
              st_n = ST_RUN;
              if (!hit_q && !ilim_i) oc_n = '0;
            end else begin
              tmr_n = tmr_q + 1'b1;
            end
          end
        end
      end
      ST_HICCUP: if (tick) begin
        if (tmr_q == TMR_W'(HICCUP_CYCLES - 1)) st_n = ST_SOFT;
        else tmr_n = tmr_q + 1'b1;
      end
      ST_OV_SINK: if (tick && neg_lim_i) st_n = ST_OV_HOLD;
      ST_OV_HOLD: if (tick && fb_lo_i) st_n = ST_SOFT;
      default: st_n = ST_OFF;
    endcase
    if (shut) begin
      st_n = ST_OFF;
      oc_n = '0;
    end
    if (st_n != st_q) begin
      tmr_n    = '0;
      ov_n     = '0;
      hit_n    = 1'b0;
      rev_ok_n = 1'b0;
    end
  end

  bsup_ramp #(.SS_W(SS_W), .TMR_W(TMR_W), .RAMP_W(RAMP_W)) u_ramp (
    .in_soft (st_n == ST_SOFT),
    .in_run  (st_n == ST_RUN),
    .count   (tmr_n),
    .code    (ramp_n)
  );

  bsup_pgood #(.FILTER(PG_FILTER)) u_pg (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .in_run (st_n == ST_RUN),
    .fb_ok  (fb_ok_i),
    .pgood  (pgood_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_OFF;
      tmr_q       <= '0;
      oc_q        <= '0;
      ov_q        <= '0;
      hit_q       <= 1'b0;
      rev_ok_q    <= 1'b0;
      run_o       <= 1'b0;
      ramp_o      <= '0;
      force_ls_o  <= 1'b0;
      block_rev_o <= 1'b0;
    end else begin
      st_q        <= st_n;
      tmr_q       <= tmr_n;
      oc_q        <= oc_n;
      ov_q        <= ov_n;
      hit_q       <= hit_n;
      rev_ok_q    <= rev_ok_n;
      run_o       <= (st_n == ST_SOFT) || (st_n == ST_RUN);
      ramp_o      <= ramp_n;
      force_ls_o  <= (st_n == ST_OV_SINK);
      block_rev_o <= (st_n == ST_SOFT) && !rev_ok_n;
    end
  end
endmodule

// File: rtl/bsup_checker.sv
module bsup_checker #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              uv_i,
  input logic              ot_i,
  input logic              fb_ok_i,
  input logic              run_o,
  input logic [RAMP_W-1:0] ramp_o,
  input logic              force_ls_o,
  input logic              block_rev_o,
  input logic              pgood_o
);
  // R12: power-good only while running at full ramp
  a_r12_pg_only_running: assert property (@(posedge clk) disable iff (rst)
    pgood_o |-> (run_o && ramp_o == {RAMP_W{1'b1}}));

  // R5: any shutdown request leaves the stage idle on the next edge
  a_r5_shutdown_off: assert property (@(posedge clk) disable iff (rst)
    (!en_i || uv_i || ot_i) |=> (!run_o && !force_ls_o && !pgood_o));

  // R9: switching and forced low-side never coexist
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({run_o, force_ls_o}));

  // R9: the sink state is entered only from an active state
  a_r9_sink_from_run: assert property (@(posedge clk) disable iff (rst)
    $rose(force_ls_o) |-> $past(run_o));

  // R4: reverse blocking only during soft start
  a_r4_block_in_soft: assert property (@(posedge clk) disable iff (rst)
    block_rev_o |-> (run_o && !pgood_o));

  // R11: power-good falls while running only after feedback left the window
  a_r11_pg_fall_cause: assert property (@(posedge clk) disable iff (rst)
    ($fell(pgood_o) && run_o) |-> $past(!fb_ok_i));

  // R2: ramp never decreases while the stage keeps running
  a_r2_ramp_monotonic: assert property (@(posedge clk) disable iff (rst)
    (run_o && $past(run_o)) |-> (ramp_o >= $past(ramp_o)));
endmodule

bind buck_supervisor bsup_checker #(.RAMP_W(RAMP_W)) u_bsup_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .uv_i        (uv_i),
  .ot_i        (ot_i),
  .fb_ok_i     (fb_ok_i),
  .run_o       (run_o),
  .ramp_o      (ramp_o),
  .force_ls_o  (force_ls_o),
  .block_rev_o (block_rev_o),
  .pgood_o     (pgood_o)
);

// File: tb/tb_buck_supervisor.sv
`timescale 1ns/1ps
module tb_buck_supervisor;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1, en_i = 1'b0, uv_i = 1'b0, ot_i = 1'b0;
  logic fb_hi_i = 1'b0, fb_lo_i = 1'b0, fb_ok_i = 1'b1;
  logic neg_lim_i = 1'b0, ilim_i = 1'b0, ss_above_fb_i = 1'b0;
  logic run_o, force_ls_o, block_rev_o, pgood_o;
  logic [RW-1:0] ramp_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  buck_supervisor #(
    .SS_CYCLES(16), .HICCUP_CYCLES(32), .OC_LIMIT(3),
    .OV_FILTER(4), .PG_FILTER(4), .RAMP_W(RW)
  ) dut (
    .clk(clk), .rst(rst), .tick(tick), .en_i(en_i), .uv_i(uv_i), .ot_i(ot_i),
    .fb_hi_i(fb_hi_i), .fb_lo_i(fb_lo_i), .fb_ok_i(fb_ok_i),
    .neg_lim_i(neg_lim_i), .ilim_i(ilim_i), .ss_above_fb_i(ss_above_fb_i),
    .run_o(run_o), .ramp_o(ramp_o), .force_ls_o(force_ls_o),
    .block_rev_o(block_rev_o), .pgood_o(pgood_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_hit();
    ilim_i = 1'b1; step(1); ilim_i = 1'b0; step(1);
  endtask

  task automatic t_reset();
    step(3); rst = 1'b0; step(3);
    chk("R1", "run", run_o, 0);
    chk("R1", "ramp", ramp_o, 0);
    chk("R1", "force_ls", force_ls_o, 0);
    chk("R1", "block_rev", block_rev_o, 0);
    chk("R1", "pgood", pgood_o, 0);
  endtask

  task automatic t_soft_start();
    en_i = 1'b1; step(1);
    chk("R2", "run at entry", run_o, 1);
    chk("R2", "ramp at entry", ramp_o, 0);
    chk("R4", "block at entry", block_rev_o, 1);
    chk("R12", "pgood in soft", pgood_o, 0);
    step(5);
    chk("R2", "ramp after 5", ramp_o, 5);
    tick = 1'b0; step(4);
    chk("R3", "ramp frozen", ramp_o, 5);
    tick = 1'b1;
    ss_above_fb_i = 1'b1; step(1);
    chk("R4", "block released", block_rev_o, 0);
    chk("R2", "ramp 6", ramp_o, 6);
    ss_above_fb_i = 1'b0; step(1);
    chk("R4", "block stays low", block_rev_o, 0);
    step(8);
    chk("R2", "ramp top of soft", ramp_o, 15);
    chk("R12", "pgood still low", pgood_o, 0);
    step(1);
    chk("R2", "running ramp", ramp_o, 15);
    chk("R11", "pgood rises", pgood_o, 1);
    chk("R4", "block in run", block_rev_o, 0);
  endtask

  task automatic t_pgood_filter();
    fb_ok_i = 1'b0; step(3);
    chk("R11", "short excursion", pgood_o, 1);
    fb_ok_i = 1'b1; step(1);
    fb_ok_i = 1'b0; step(3);
    chk("R11", "three bad strobes", pgood_o, 1);
    step(1);
    chk("R11", "fourth bad strobe", pgood_o, 0);
    fb_ok_i = 1'b1; step(1);
    chk("R11", "pgood recovers", pgood_o, 1);
  endtask

  task automatic t_overvoltage();
    pulse_hit(); pulse_hit(); pulse_hit();
    chk("R6", "three hits tolerated", run_o, 1);
    fb_hi_i = 1'b1; step(3);
    chk("R9", "three high strobes", force_ls_o, 0);
    fb_hi_i = 1'b0; step(1);
    fb_hi_i = 1'b1; step(3);
    chk("R9", "count restarted", force_ls_o, 0);
    step(1);
    chk("R9", "sink entered", force_ls_o, 1);
    chk("R9", "run off in sink", run_o, 0);
    chk("R12", "pgood in sink", pgood_o, 0);
    fb_hi_i = 1'b0; step(3);
    chk("R10", "sink holds", force_ls_o, 1);
    neg_lim_i = 1'b1; step(1); neg_lim_i = 1'b0;
    chk("R10", "sink released", force_ls_o, 0);
    chk("R10", "hold both off", run_o, 0);
    step(3);
    chk("R10", "hold waits", run_o, 0);
    fb_lo_i = 1'b1; step(1); fb_lo_i = 1'b0;
    chk("R10", "restart run", run_o, 1);
    chk("R10", "restart ramp", ramp_o, 0);
    step(16);
    chk("R10", "back to running", pgood_o, 1);
  endtask

  task automatic t_overcurrent();
    pulse_hit(); pulse_hit(); pulse_hit();
    chk("R8", "count cleared by clean soft start", run_o, 1);
    ilim_i = 1'b1; step(1); ilim_i = 1'b0;
    chk("R6", "hiccup run", run_o, 0);
    chk("R6", "hiccup force_ls", force_ls_o, 0);
    chk("R12", "pgood in hiccup", pgood_o, 0);
    step(31);
    chk("R7", "hiccup still on", run_o, 0);
    step(1);
    chk("R7", "retry run", run_o, 1);
    chk("R7", "retry ramp", ramp_o, 0);
  endtask

  task automatic t_shutdown();
    step(3);
    chk("R5", "ramp before uv", ramp_o, 3);
    uv_i = 1'b1; step(1);
    chk("R5", "uv run", run_o, 0);
    chk("R5", "uv ramp", ramp_o, 0);
    uv_i = 1'b0; step(1);
    chk("R5", "fresh soft run", run_o, 1);
    chk("R5", "fresh soft ramp", ramp_o, 0);
    step(16);
    chk("R5", "running again", pgood_o, 1);
    pulse_hit(); pulse_hit(); pulse_hit();
    ilim_i = 1'b1; ot_i = 1'b1; step(1);
    ilim_i = 1'b0; ot_i = 1'b0;
    chk("R5", "ot wins run", run_o, 0);
    step(1);
    chk("R5", "no hiccup after ot", run_o, 1);
    chk("R5", "ramp restarts", ramp_o, 0);
    en_i = 1'b0; step(1);
    chk("R5", "disable run", run_o, 0);
    step(3);
    chk("R1", "stays off", run_o, 0);
    en_i = 1'b1; step(1);
    chk("R5", "reenable", run_o, 1);
  endtask

  initial begin
    t_reset();
    t_soft_start();
    t_pgood_filter();
    t_overvoltage();
    t_overcurrent();
    t_shutdown();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule